// File: doc/BRIEF.md
# Two-Wire Serial Shift Unit

This block assists a small controller acting as a slave on an I2C-style two-wire bus. It has no protocol state machine. It provides an 8-bit shift register that samples SDA on every rising SCL edge. It provides a 4-bit counter that advances on both SCL edges. It has a detector for start and stop conditions. The unit stretches the bus clock by pulling SCL low at two points: after a start condition, and when the counter wraps. Firmware decides everything at the byte level. This includes address matching, whether to acknowledge, and when to release the clock.

Firmware uses a four-entry register port. Entry 0 is the data byte. Entry 1 holds the flags, which are cleared by writing a one. Entry 2 is the counter, which can be preloaded. Entry 3 is the control byte.

Both pins are open-drain. The unit only drives pull-low enables, and the bus resolves each line as a wired-AND with a pull-up. Both pin inputs pass through a synchroniser (two stages by default) before any edge detection.

Top module: `twi_shift_unit`

## Requirements
- R1: After reset:
  - the data entry (sel 0) reads 0xFF;
  - the flag entry (sel 1), the counter entry (sel 2) and the control entry (sel 3) read 0;
  - both pull enables and both interrupt outputs are low.
- R2: When SDA falls while SCL is high, the start flag (bit 7 of sel 1) is set. With the start interrupt enable (bit 1 of sel 3) set, `irq_start_o` goes high.
- R3: At the first SCL falling edge after the start flag is set, SCL is pulled low. SCL stays held until firmware writes sel 1 with bit 7 set, which clears the start flag.
- R4: On each rising SCL edge, the SDA level is shifted into the data byte at bit 0, so the byte arrives MSB first. Reading sel 0 returns the byte.
- R5: The counter advances by one on every rising and every falling SCL edge. Writing sel 2 loads it from bits 3:0.
- R6: When the counter wraps from 15 to 0, the overflow flag (bit 6 of sel 1) is set and SCL is pulled low. With the overflow interrupt enable (bit 2 of sel 3) set, `irq_ovf_o` goes high.
- R7: Writing sel 1 with bit 6 set clears the overflow flag and releases its SCL hold. Writing sel 1 with bit 6 clear leaves the flag and the hold unchanged.
- R8: If the counter is loaded with 14, one full SCL pulse (the acknowledge clock) causes an overflow.
- R9: `sda_pull_o` is high only when the output enable (bit 0 of sel 3) is set and the SDA output bit is 0. The SDA output bit takes bit 7 of a written data byte, and takes bit 7 of the data byte at each SCL falling edge. Transmitted bits therefore appear MSB first and never change while SCL is high.
- R10: When SDA rises while SCL is high, the stop flag (bit 5 of sel 1) is set and SCL is not held. Writing sel 1 with bit 5 set clears the stop flag.
- R11: SCL is released only when neither the start hold nor the overflow hold is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull_o | output | 1 | Pull SCL low |
| sda_pull_o | output | 1 | Pull SDA low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 data, 1 flags, 2 counter, 3 control) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected entry |
| irq_start_o | output | 1 | Start interrupt request |
| irq_ovf_o | output | 1 | Overflow interrupt request |

## Verification
The bench targets the following corner cases.

- **Start hold arming on the falling edge.** If the start hold were armed on the start itself, SCL would be pulled while still high and the master would see a spurious edge.
- **Start hold and overflow hold set on the same edge.** A design that ORs the holds incorrectly would release SCL when only one of the two is cleared.
- **Counter preloaded to 14 for a single acknowledge clock.** If the counter counted only one edge per bit, it would not wrap after that one pulse.
- **Loopback transmit with the output enabled.** If the output bit followed the shift register directly, SDA would change while SCL is high. That would corrupt the byte and trigger false start or stop detection.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_CNT  = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_W        = 3;
  localparam int unsigned CTRL_OE       = 0;
  localparam int unsigned CTRL_IE_START = 1;
  localparam int unsigned CTRL_IE_OVF   = 2;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  // idle bus is high, so reset to ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '1;
    else         stg[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[i] <= '1;
      else         stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/twi_cond_det.sv
module twi_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SCL high on both samples, SDA moved
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/twi_edge_cnt.sv
module twi_edge_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (edge_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = edge_i & ~load_i & (cnt_q == CntMax);
endmodule

// File: rtl/twi_shift_unit.sv
module twi_shift_unit
  import twi_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_start_o,
  output logic              irq_ovf_o
);
  localparam int unsigned STAT_START = DATA_W - 1;
  localparam int unsigned STAT_OVF   = DATA_W - 2;
  localparam int unsigned STAT_STOP  = DATA_W - 3;

  logic [1:0] pins_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic [CNT_W-1:0] cnt_q;
  logic       cnt_edge, cnt_wrap;

  logic [DATA_W-1:0] shreg_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic sda_bit_q;
  logic start_flag_q, start_flag_d, start_hold_q, start_hold_d;
  logic ovf_flag_q, stop_flag_q;

  reg_sel_e sel;
  logic wr_data, wr_stat, wr_cnt, wr_ctrl;
  logic clr_start, clr_ovf, clr_stop;

  twi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (pins_s)
  );
  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  twi_cond_det u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  assign sel     = reg_sel_e'(reg_sel_i);
  assign wr_data = reg_we_i & (sel == REG_DATA);
  assign wr_stat = reg_we_i & (sel == REG_STAT);
  assign wr_cnt  = reg_we_i & (sel == REG_CNT);
  assign wr_ctrl = reg_we_i & (sel == REG_CTRL);

  assign clr_start = wr_stat & reg_wdata_i[STAT_START];
  assign clr_ovf   = wr_stat & reg_wdata_i[STAT_OVF];
  assign clr_stop  = wr_stat & reg_wdata_i[STAT_STOP];

  assign cnt_edge = scl_rise | scl_fall;

  twi_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .edge_i     (cnt_edge),
    .load_i     (wr_cnt),
    .load_val_i (reg_wdata_i[CNT_W-1:0]),
    .cnt_o      (cnt_q),
    .wrap_o     (cnt_wrap)
  );

  // start hold arms on the first SCL fall after the start, drops with the flag
  assign start_flag_d = start_det | (start_flag_q & ~clr_start);
  assign start_hold_d = start_flag_d & (start_hold_q | (scl_fall & start_flag_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q      <= '1;
      sda_bit_q    <= 1'b1;
      ctrl_q       <= '0;
      start_flag_q <= 1'b0;
      start_hold_q <= 1'b0;
      ovf_flag_q   <= 1'b0;
      stop_flag_q  <= 1'b0;
    end else begin
      if (wr_data) begin
        shreg_q   <= reg_wdata_i;
        sda_bit_q <= reg_wdata_i[DATA_W-1];
      end else begin
        if (scl_rise) shreg_q <= {shreg_q[DATA_W-2:0], sda_s};
        // output bit moves only while SCL is low
        if (scl_fall) sda_bit_q <= shreg_q[DATA_W-1];
      end
      if (wr_ctrl) ctrl_q <= reg_wdata_i[CTRL_W-1:0];
      start_flag_q <= start_flag_d;
      start_hold_q <= start_hold_d;
      if (cnt_wrap)     ovf_flag_q <= 1'b1;
      else if (clr_ovf) ovf_flag_q <= 1'b0;
      if (stop_det)      stop_flag_q <= 1'b1;
      else if (clr_stop) stop_flag_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      REG_DATA: reg_rdata_o = shreg_q;
      REG_STAT: begin
        reg_rdata_o[STAT_START] = start_flag_q;
        reg_rdata_o[STAT_OVF]   = ovf_flag_q;
        reg_rdata_o[STAT_STOP]  = stop_flag_q;
      end
      REG_CNT:  reg_rdata_o[CNT_W-1:0]  = cnt_q;
      REG_CTRL: reg_rdata_o[CTRL_W-1:0] = ctrl_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign scl_pull_o  = start_hold_q | ovf_flag_q;
  assign sda_pull_o  = ctrl_q[CTRL_OE] & ~sda_bit_q;
  assign irq_start_o = start_flag_q & ctrl_q[CTRL_IE_START];
  assign irq_ovf_o   = ovf_flag_q & ctrl_q[CTRL_IE_OVF];
endmodule

// File: rtl/twi_shift_unit_chk.sv
module twi_shift_unit_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_pull_i,
  input logic             start_det_i,
  input logic             stop_det_i,
  input logic             scl_fall_i,
  input logic             edge_i,
  input logic             load_i,
  input logic             clr_start_i,
  input logic             start_flag_i,
  input logic             stop_flag_i,
  input logic             ovf_flag_i,
  input logic             start_hold_i,
  input logic [CNT_W-1:0] cnt_i
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  // R2
  start_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det_i |=> start_flag_i) else $error("start flag not set");

  // R3
  hold_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_fall_i && start_flag_i && !clr_start_i) |=> start_hold_i) else $error("start hold not armed");

  // R3
  start_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_hold_i |-> scl_pull_i) else $error("SCL free during start hold");

  // R5
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && !load_i) |=> (cnt_i == CNT_W'($past(cnt_i) + 1'b1))) else $error("counter step");

  // R6
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && !load_i && cnt_i == CntMax) |=> ovf_flag_i) else $error("wrap without overflow");

  // R6
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_flag_i |-> scl_pull_i) else $error("SCL free during overflow");

  // R10
  stop_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_i |=> stop_flag_i) else $error("stop flag not set");
endmodule

bind twi_shift_unit twi_shift_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_pull_i   (scl_pull_o),
  .start_det_i  (start_det),
  .stop_det_i   (stop_det),
  .scl_fall_i   (scl_fall),
  .edge_i       (cnt_edge),
  .load_i       (wr_cnt),
  .clr_start_i  (clr_start),
  .start_flag_i (start_flag_q),
  .stop_flag_i  (stop_flag_q),
  .ovf_flag_i   (ovf_flag_q),
  .start_hold_i (start_hold_q),
  .cnt_i        (cnt_q)
);

// File: tb/twi_shift_unit_test.sv
module twi_shift_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_pull, sda_pull;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq_start, irq_ovf;
  logic scl_line, sda_line;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  // open-drain wired-AND with pull-up
  assign scl_line = scl_m & ~scl_pull;
  assign sda_line = sda_m & ~sda_pull;

  twi_shift_unit uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_line),
    .sda_i       (sda_line),
    .scl_pull_o  (scl_pull),
    .sda_pull_o  (sda_pull),
    .reg_we_i    (reg_we),
    .reg_sel_i   (reg_sel),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_start_o (irq_start),
    .irq_ovf_o   (irq_ovf)
  );

  function automatic logic [3:0] exp_cnt(input logic [3:0] load, input int edges);
    return 4'(int'(load) + edges);
  endfunction

  function automatic logic [7:0] exp_stat(input logic st, input logic ov, input logic sp);
    return {st, ov, sp, 5'b0};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_sel = a;
    #1 d = reg_rdata;
  endtask

  task automatic bit_clk(input logic b, output logic seen);
    sda_m = b; settle();
    scl_m = 1'b1; settle();
    seen = sda_line;
    scl_m = 1'b0; settle();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL timeout: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] v, b;
    logic seen;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    rd(2'd0, v); check("R1 data", v, 8'hFF);
    rd(2'd1, v); check("R1 flags", v, 8'h00);
    rd(2'd2, v); check("R1 cnt", v, 8'h00);
    rd(2'd3, v); check("R1 ctrl", v, 8'h00);
    check("R1 pulls", {6'b0, scl_pull, sda_pull}, 8'h00);
    check("R1 irqs", {6'b0, irq_start, irq_ovf}, 8'h00);

    wr(2'd3, 8'h06);
    // R2 start
    sda_m = 1'b0; settle();
    rd(2'd1, v); check("R2 start flag", v, exp_stat(1, 0, 0));
    check("R2 irq_start", {7'b0, irq_start}, 8'h01);
    check("R3 no hold while SCL high", {7'b0, scl_pull}, 8'h00);
    // R3 hold on falling edge
    scl_m = 1'b0; settle();
    check("R3 hold after fall", {7'b0, scl_pull}, 8'h01);
    scl_m = 1'b1; settle();
    check("R3 line held low", {7'b0, scl_line}, 8'h00);
    scl_m = 1'b0;
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h80); settle();
    check("R3 released after clear", {7'b0, scl_pull}, 8'h00);
    check("R2 irq_start cleared", {7'b0, irq_start}, 8'h00);

    // R4/R5/R6 address byte
    b = 8'($urandom);
    for (int i = 7; i >= 0; i--) begin
      bit_clk(b[i], seen);
      if (i == 5) begin
        rd(2'd2, v); check("R5 cnt mid-byte", v, {4'b0, exp_cnt(4'd0, 6)});
      end
    end
    rd(2'd0, v); check("R4 rx byte", v, b);
    rd(2'd2, v); check("R5 cnt after byte", v, {4'b0, exp_cnt(4'd0, 16)});
    rd(2'd1, v); check("R6 ovf flag", v, exp_stat(0, 1, 0));
    check("R6 scl hold", {7'b0, scl_pull}, 8'h01);
    check("R6 irq_ovf", {7'b0, irq_ovf}, 8'h01);

    // R7 write zero has no effect
    wr(2'd1, 8'h00); settle();
    rd(2'd1, v); check("R7 w0 keeps ovf", v, exp_stat(0, 1, 0));
    check("R7 w0 keeps hold", {7'b0, scl_pull}, 8'h01);

    // R8/R9 acknowledge
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h07);
    wr(2'd2, 8'h0E); settle();
    check("R9 sda pulled for ack", {7'b0, sda_pull}, 8'h01);
    wr(2'd1, 8'h40); settle();
    check("R7 ovf release", {7'b0, scl_pull}, 8'h00);
    check("R7 irq_ovf cleared", {7'b0, irq_ovf}, 8'h00);
    bit_clk(1'b1, seen);
    check("R9 ack level on SDA", {7'b0, seen}, 8'h00);
    rd(2'd1, v); check("R8 ovf after ack pulse", v, exp_stat(0, 1, 0));
    check("R8 scl hold after ack", {7'b0, scl_pull}, 8'h01);
    wr(2'd3, 8'h06); settle();
    check("R9 oe off no pull", {7'b0, sda_pull}, 8'h00);

    // random receive and transmit bytes
    for (int k = 0; k < 24; k++) begin
      logic tx;
      logic [7:0] got;
      tx = 1'($urandom);
      b = 8'($urandom);
      if (k == 0) b = 8'h00;
      if (k == 1) b = 8'hFF;
      got = 8'h00;
      if (tx) begin
        wr(2'd0, b);
        wr(2'd3, 8'h07);
      end
      wr(2'd2, 8'h00);
      wr(2'd1, 8'h40); settle();
      for (int i = 7; i >= 0; i--) begin
        bit_clk(tx ? 1'b1 : b[i], seen);
        got[i] = seen;
      end
      if (tx) begin
        check("R9 tx bits on SDA", got, b);
        wr(2'd3, 8'h06);
      end
      rd(2'd0, v); check("R4 shifted byte", v, b);
      rd(2'd1, v); check("R6 ovf per byte", v, exp_stat(0, 1, 0));
    end

    // R10 stop
    sda_m = 1'b0; settle();
    wr(2'd1, 8'h40); settle();
    scl_m = 1'b1; settle();
    sda_m = 1'b1; settle();
    rd(2'd1, v); check("R10 stop flag", v, exp_stat(0, 0, 1));
    check("R10 no stretch", {7'b0, scl_pull}, 8'h00);
    wr(2'd1, 8'h20);
    rd(2'd1, v); check("R10 stop cleared", v, exp_stat(0, 0, 0));

    // R11 both holds on one edge
    sda_m = 1'b0; settle();
    wr(2'd2, 8'h0F);
    scl_m = 1'b0; settle();
    rd(2'd1, v); check("R11 both flags", v, exp_stat(1, 1, 0));
    wr(2'd1, 8'h80); settle();
    check("R11 ovf still holds", {7'b0, scl_pull}, 8'h01);
    wr(2'd1, 8'h40); settle();
    check("R11 released", {7'b0, scl_pull}, 8'h00);

    finish_run();
  end
endmodule